// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves 32-bit words between a local memory and a host memory. Software never touches the data. It builds a chain of three-word descriptors in host memory, loads a pointer to that chain, enables a direction and writes a command. The engine reads the chain into an internal descriptor table until it finds the entry flagged as final. It then copies each described region one word at a time, reading from the source side and writing to the destination side.

There are two directions. The inbound direction (read) carries data from host memory to local memory. Its table holds only a small number of descriptor sets. The outbound direction (write) carries data from local memory to host memory and has a deeper table. Only one transfer runs at a time. Status shows which direction is busy, sticky error bits for each direction, and a separate flag for a malformed chain. A one-cycle pulse per direction marks a transfer that finished normally.

Both memory sides use a simple request/acknowledge port. The engine drives one request at a time and holds it until the acknowledge. An error flag may accompany the acknowledge.

Top module: `chain_dma`

## Requirements
- R1: Writing 1 to the command register starts an inbound transfer (host to local). Writing 2 starts an outbound transfer (local to host). A start only takes effect when the engine is idle and the enable bit for its direction is set (enable bit 0 inbound, bit 1 outbound). Otherwise it is ignored.
- R2: Registers are selected by word index: 0 command, 1 enable, 2 status, 3 inbound chain pointer, 4 outbound chain pointer. Status bit 0 is inbound busy, bit 1 outbound busy, bit 2 inbound error, bit 3 outbound error and bit 4 chain error. After reset every readable register is zero.
- R3: Descriptor n sits at chain pointer + 12*n and has three words, in this order: local byte address, host byte address, length word. In the length word, bit 31 flags the final descriptor and bits 30:0 give a byte count. The engine moves ceil(count/4) words and advances both addresses by 4 per word.
- R4: The outbound table holds up to WR_SETS descriptors and the inbound table holds up to RD_SETS. A chain that fills its table without a final flag sets the chain error bit, clears busy and moves no data.
- R5: A descriptor with a byte count of zero sets the chain error bit, clears busy and moves no data.
- R6: When the final word of the final descriptor has been written, busy clears and the done output for that direction is high for exactly one cycle.
- R7: Command 4 (stop) during a transfer ends it after the word in flight. Every word moved is complete, busy clears, no done pulse is raised and the error bits are kept. A stop while idle has no effect.
- R8: Command 0 (cancel) aborts like a stop and also clears all error bits. Error bits are otherwise sticky across later transfers.
- R9: An error flag on any acknowledge during a transfer sets the error bit for the running direction, clears busy and raises no done pulse.
- R10: At most one of the two memory requests is high at a time. A request stays high with a stable address until it is acknowledged.
- R11: Data words pass from source to destination unchanged. The byte at the lowest address is carried in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_req | output | 1 | Host-side request |
| host_we | output | 1 | Host-side request is a write |
| host_addr | output | 32 | Host byte address |
| host_wdata | output | 32 | Host write data |
| host_ack | input | 1 | Host request accepted |
| host_err | input | 1 | Host response error, valid with ack |
| host_rdata | input | 32 | Host read data, valid with ack |
| loc_req | output | 1 | Local-side request |
| loc_we | output | 1 | Local-side request is a write |
| loc_addr | output | 32 | Local byte address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local request accepted |
| loc_err | input | 1 | Local response error, valid with ack |
| loc_rdata | input | 32 | Local read data, valid with ack |
| done_rd | output | 1 | Inbound transfer completed (one cycle) |
| done_wr | output | 1 | Outbound transfer completed (one cycle) |

## Verification
The bench builds the engine with its default table depths: eight outbound sets and one inbound set. With eight sets, a chain that exactly fills the outbound table can be shown to complete, and the same chain without a final flag can be shown to raise the chain error. With one inbound set, the smallest overflow case is reachable: an inbound chain whose first descriptor is not final. Stop and cancel are issued a few words into a sixteen-word transfer, so the bench can confirm that an abort lands on a word boundary.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int WR_SETS = 8,
  parameter int RD_SETS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        host_req,
  output logic        host_we,
  output logic [31:0] host_addr,
  output logic [31:0] host_wdata,
  input  logic        host_ack,
  input  logic        host_err,
  input  logic [31:0] host_rdata,
  output logic        loc_req,
  output logic        loc_we,
  output logic [31:0] loc_addr,
  output logic [31:0] loc_wdata,
  input  logic        loc_ack,
  input  logic        loc_err,
  input  logic [31:0] loc_rdata,
  output logic        done_rd,
  output logic        done_wr
);
  localparam int SETS = (WR_SETS > RD_SETS) ? WR_SETS : RD_SETS;
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam logic [2:0] A_CMD = 3'd0, A_EN = 3'd1, A_STAT = 3'd2, A_RPTR = 3'd3, A_WPTR = 3'd4;

  typedef enum logic [2:0] {IDLE, FETCH, LOAD, SRC, DST} st_t;
  st_t st;

  logic          dir;
  logic [1:0]    en;
  logic [31:0]   rptr, wptr, lptr;
  logic [2:0]    err;
  logic [SW-1:0] fs, es, ls;
  logic [1:0]    fk;
  logic [31:0]   t_loc [SETS];
  logic [31:0]   t_hst [SETS];
  logic [30:0]   t_len [SETS];
  logic [31:0]   c_loc, c_hst, hold;
  logic [29:0]   rem;
  logic          stop_pend;

  wire busy       = (st != IDLE);
  wire cmd_wr     = reg_we && (reg_addr == A_CMD);
  wire cmd_cancel = cmd_wr && (reg_wdata == 32'd0);
  wire cmd_stop   = cmd_wr && (reg_wdata == 32'd4);
  wire go_rd      = cmd_wr && (reg_wdata == 32'd1) && !busy && en[0];
  wire go_wr      = cmd_wr && (reg_wdata == 32'd2) && !busy && en[1];
  wire stop_now   = stop_pend || cmd_cancel || cmd_stop;
  wire [SW-1:0] lim = dir ? SW'(WR_SETS - 1) : SW'(RD_SETS - 1);

  assign host_req   = (st == FETCH) || (st == SRC && !dir) || (st == DST && dir);
  assign host_we    = (st == DST);
  assign host_addr  = (st == FETCH) ? lptr + 32'(fs) * 32'd12 + 32'({fk, 2'b00}) : c_hst;
  assign host_wdata = hold;
  assign loc_req    = (st == SRC && dir) || (st == DST && !dir);
  assign loc_we     = (st == DST);
  assign loc_addr   = c_loc;
  assign loc_wdata  = hold;

  wire        ack = host_req ? host_ack : loc_ack;
  wire        berr = host_req ? host_err : loc_err;
  wire [31:0] rsp = host_req ? host_rdata : loc_rdata;
  wire        len_word = (fk == 2'd2);
  wire [31:0] words = ({1'b0, t_len[es]} + 32'd3) >> 2;

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = {30'd0, en};
      A_STAT:  reg_rdata = {27'd0, err, busy && dir, busy && !dir};
      A_RPTR:  reg_rdata = rptr;
      A_WPTR:  reg_rdata = wptr;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (st == FETCH && host_ack && !host_err) begin
      case (fk)
        2'd0:    t_loc[fs] <= host_rdata;
        2'd1:    t_hst[fs] <= host_rdata;
        default: t_len[fs] <= host_rdata[30:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; dir <= 1'b0; en <= 2'd0; rptr <= '0; wptr <= '0; lptr <= '0;
      err <= '0; fs <= '0; es <= '0; ls <= '0; fk <= '0;
      c_loc <= '0; c_hst <= '0; hold <= '0; rem <= '0; stop_pend <= 1'b0;
      done_rd <= 1'b0; done_wr <= 1'b0;
    end else begin
      done_rd <= 1'b0;
      done_wr <= 1'b0;
      if (reg_we && reg_addr == A_EN)   en <= reg_wdata[1:0];
      if (reg_we && reg_addr == A_RPTR) rptr <= reg_wdata;
      if (reg_we && reg_addr == A_WPTR) wptr <= reg_wdata;
      if (cmd_cancel) err <= '0;
      if ((cmd_cancel || cmd_stop) && busy) stop_pend <= 1'b1;
      case (st)
        IDLE: begin
          stop_pend <= 1'b0;
          if (go_rd || go_wr) begin
            dir <= go_wr; lptr <= go_wr ? wptr : rptr; fs <= '0; fk <= '0; st <= FETCH;
          end
        end
        FETCH: if (ack) begin
          if (berr) begin
            err[dir] <= 1'b1; st <= IDLE;
          end else if (len_word && host_rdata[30:0] == 31'd0) begin
            err[2] <= 1'b1; st <= IDLE;
          end else if (stop_now) begin
            st <= IDLE;
          end else if (len_word && host_rdata[31]) begin
            ls <= fs; es <= '0; st <= LOAD;
          end else if (len_word && fs == lim) begin
            err[2] <= 1'b1; st <= IDLE;
          end else if (len_word) begin
            fs <= fs + 1'b1; fk <= 2'd0;
          end else begin
            fk <= fk + 2'd1;
          end
        end
        LOAD: begin
          if (stop_now) st <= IDLE;
          else begin
            c_loc <= t_loc[es]; c_hst <= t_hst[es]; rem <= words[29:0]; st <= SRC;
          end
        end
        SRC: if (ack) begin
          if (berr) begin
            err[dir] <= 1'b1; st <= IDLE;
          end else begin
            hold <= rsp; st <= DST;
          end
        end
        DST: if (ack) begin
          if (berr) begin
            err[dir] <= 1'b1; st <= IDLE;
          end else begin
            c_loc <= c_loc + 32'd4; c_hst <= c_hst + 32'd4; rem <= rem - 30'd1;
            if (stop_now) st <= IDLE;
            else if (rem != 30'd1) st <= SRC;
            else if (es != ls) begin
              es <= es + 1'b1; st <= LOAD;
            end else begin
              done_rd <= !dir; done_wr <= dir; st <= IDLE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_one_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && loc_req));
  p_host_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !host_ack |=> host_req && $stable(host_addr));
  p_loc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req && !loc_ack |=> loc_req && $stable(loc_addr));
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rd || done_wr) |-> !busy && $past(busy));
  p_chain_err_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[2]) |-> !busy);
  p_start_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dir ? $past(en[1]) : $past(en[0])));
endmodule

// File: tb/chain_dma_test.sv
`timescale 1ns/1ps
module chain_dma_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic host_req, host_we, host_ack, host_err, loc_req, loc_we, loc_ack, loc_err;
  logic [31:0] host_addr, host_wdata, host_rdata, loc_addr, loc_wdata, loc_rdata;
  logic done_rd, done_wr;
  logic herr_en = 1'b0, lerr_en = 1'b0;
  logic [31:0] hmem [1024];
  logic [31:0] lmem [1024];
  int n_chk = 0, n_fail = 0, cnt_rd = 0, cnt_wr = 0, overlap = 0, req_cyc = 0;

  always #2.5 clk = ~clk;

  chain_dma uut (.*);

  assign host_ack   = host_req;
  assign loc_ack    = loc_req;
  assign host_err   = host_req && herr_en && host_addr[11:8] == 4'h8;
  assign loc_err    = loc_req && lerr_en && loc_addr[11:8] == 4'h2;
  assign host_rdata = hmem[host_addr[11:2]];
  assign loc_rdata  = lmem[loc_addr[11:2]];

  always @(posedge clk) begin
    if (host_req && host_we && !host_err) hmem[host_addr[11:2]] <= host_wdata;
    if (loc_req && loc_we && !loc_err) lmem[loc_addr[11:2]] <= loc_wdata;
    if (done_rd) cnt_rd <= cnt_rd + 1;
    if (done_wr) cnt_wr <= cnt_wr + 1;
    if (host_req && loc_req) overlap <= overlap + 1;
    if (host_req || loc_req) req_cyc <= req_cyc + 1;
  end

  // dir, sets, length bytes, final flag on last set, expected status, expected done
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 4'd1, 8'd16, 1'b1, 5'd0,  1'b1},
    {1'b0, 4'd1, 8'd5,  1'b1, 5'd0,  1'b1},
    {1'b1, 4'd1, 8'd8,  1'b1, 5'd0,  1'b1},
    {1'b1, 4'd3, 8'd12, 1'b1, 5'd0,  1'b1},
    {1'b1, 4'd8, 8'd4,  1'b1, 5'd0,  1'b1},
    {1'b1, 4'd8, 8'd4,  1'b0, 5'd16, 1'b0},
    {1'b0, 4'd2, 8'd4,  1'b1, 5'd16, 1'b0},
    {1'b1, 4'd2, 8'd0,  1'b1, 5'd16, 1'b0},
    {1'b0, 4'd1, 8'd0,  1'b1, 5'd16, 1'b0},
    {1'b1, 4'd1, 8'd64, 1'b1, 5'd0,  1'b1}
  };

  function automatic logic [31:0] pat(int idx);
    return 32'h5A000000 ^ (idx * 32'h00010203);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit idle = 1'b0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      rd_reg(3'd2, s);
      idle = (s[1:0] == 2'b00);
    end
    if (!idle) chk(1'b0, req, 32'd1, 32'd0);
  endtask

  task automatic setup(input bit dir, input int n, input int len, input bit last);
    for (int i = 0; i < 8; i++) begin
      hmem[i*3]   = 32'h200 + i * 64;
      hmem[i*3+1] = 32'h800 + i * 64;
      hmem[i*3+2] = {(last && i == n - 1), 31'(len)};
    end
    for (int w = 0; w < 128; w++) begin
      hmem[512 + w] = dir ? 32'd0 : pat(512 + w);
      lmem[128 + w] = dir ? pat(128 + w) : 32'd0;
    end
    cnt_rd = 0; cnt_wr = 0;
  endtask

  function automatic int data_miss(input bit dir, input int n, input int words, input bit moved);
    int miss = 0;
    for (int i = 0; i < n; i++)
      for (int w = 0; w < 16; w++) begin
        int s = (dir ? 128 : 512) + i * 16 + w;
        int d = (dir ? 512 : 128) + i * 16 + w;
        logic [31:0] e = (moved && w < words) ? pat(s) : 32'd0;
        logic [31:0] a = dir ? hmem[d] : lmem[d];
        if (a !== e) miss++;
      end
    return miss;
  endfunction

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int k;
    for (int i = 0; i < 1024; i++) begin hmem[i] = 32'd0; lmem[i] = 32'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset values and no requests
    for (int a = 1; a <= 4; a++) begin
      rd_reg(3'(a), s);
      chk(s == 32'd0, "R2 reset register", s, 32'd0);
    end
    chk(!host_req && !loc_req, "R10 no request after reset", {host_req, loc_req}, 0);

    // Table-driven transfers: R1 R3 R4 R5 R6 R11
    for (int v = 0; v < 10; v++) begin
      bit dir = VEC[v][19];
      int n = int'(VEC[v][18:15]);
      int len = int'(VEC[v][14:7]);
      bit last = VEC[v][6];
      logic [4:0] es = VEC[v][5:1];
      bit ed = VEC[v][0];
      wr_reg(3'd0, 32'd0);
      setup(dir, n, len, last);
      wr_reg(3'd1, 32'd3);
      wr_reg(dir ? 3'd4 : 3'd3, 32'd0);
      wr_reg(3'd0, dir ? 32'd2 : 32'd1);
      wait_idle("R1 transfer hang");
      rd_reg(3'd2, s);
      chk(s == {27'd0, es}, "R4/R5 status after chain", s, {27'd0, es});
      chk((dir ? cnt_wr : cnt_rd) == int'(ed) && (dir ? cnt_rd : cnt_wr) == 0,
          "R6 done pulse count", dir ? cnt_wr : cnt_rd, ed);
      k = data_miss(dir, n, (len + 3) / 4, ed);
      chk(k == 0, "R3/R11 copied words", k, 0);
    end

    // R1: disabled direction ignored
    wr_reg(3'd0, 32'd0);
    setup(1'b0, 1, 16, 1'b1);
    wr_reg(3'd1, 32'd2);
    k = req_cyc;
    wr_reg(3'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd_reg(3'd2, s);
    chk(s == 32'd0 && req_cyc == k, "R1 disabled inbound start ignored", s, 32'd0);
    chk(data_miss(1'b0, 1, 4, 1'b0) == 0, "R1 no data moved when disabled", 0, 0);

    // R1/R2: busy bit, and other-direction start ignored while busy
    setup(1'b1, 1, 64, 1'b1);
    wr_reg(3'd1, 32'd3);
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd0, 32'd2);
    rd_reg(3'd2, s);
    chk(s == 32'd2, "R2 outbound busy bit", s, 32'd2);
    wr_reg(3'd0, 32'd1);
    wait_idle("R1 busy run hang");
    rd_reg(3'd2, s);
    chk(s == 32'd0 && cnt_rd == 0 && cnt_wr == 1, "R1 start ignored while busy", {cnt_rd[15:0], cnt_wr[15:0]}, 32'h00000001);

    // R7: stop mid transfer
    setup(1'b1, 1, 64, 1'b1);
    wr_reg(3'd0, 32'd2);
    repeat (8) @(negedge clk);
    wr_reg(3'd0, 32'd4);
    wait_idle("R7 stop hang");
    rd_reg(3'd2, s);
    chk(s == 32'd0 && cnt_wr == 0, "R7 stop clears busy, no done", s, 32'd0);
    k = 0;
    while (k < 16 && hmem[512 + k] == pat(128 + k)) k++;
    chk(k > 0 && k < 16, "R7 partial words moved", k, 32'd8);
    chk(data_miss(1'b1, 1, k, 1'b1) == 0, "R7 whole words only", data_miss(1'b1, 1, k, 1'b1), 0);

    // R9: host error on inbound data
    setup(1'b0, 1, 16, 1'b1);
    herr_en = 1'b1;
    wr_reg(3'd0, 32'd1);
    wait_idle("R9 host error hang");
    herr_en = 1'b0;
    rd_reg(3'd2, s);
    chk(s == 32'd4 && cnt_rd == 0, "R9 inbound error bit", s, 32'd4);
    // R7: stop while idle has no effect; R8 sticky error
    wr_reg(3'd0, 32'd4);
    rd_reg(3'd2, s);
    chk(s == 32'd4, "R8 error sticky across idle stop", s, 32'd4);
    // R8: cancel clears errors
    wr_reg(3'd0, 32'd0);
    rd_reg(3'd2, s);
    chk(s == 32'd0, "R8 cancel clears errors", s, 32'd0);

    // R9: local error on outbound source read
    setup(1'b1, 1, 16, 1'b1);
    lerr_en = 1'b1;
    wr_reg(3'd0, 32'd2);
    wait_idle("R9 local error hang");
    lerr_en = 1'b0;
    rd_reg(3'd2, s);
    chk(s == 32'd8 && cnt_wr == 0, "R9 outbound error bit", s, 32'd8);

    // R8: cancel mid transfer clears error and aborts
    setup(1'b1, 1, 64, 1'b1);
    wr_reg(3'd0, 32'd2);
    repeat (8) @(negedge clk);
    wr_reg(3'd0, 32'd0);
    rd_reg(3'd2, s);
    chk(s[4:2] == 3'd0, "R8 cancel clears error at once", s, 32'd0);
    wait_idle("R8 cancel hang");
    rd_reg(3'd2, s);
    chk(s == 32'd0 && cnt_wr == 0, "R8 cancel aborts without done", s, 32'd0);

    chk(overlap == 0, "R10 both sides requested together", overlap, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule